// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block drives a small behavioural flash array from register-style control inputs and a CPU-side write port. A write to an array address starts an operation. Which operation it starts depends on the mode inputs: one word is programmed, a burst of words to one segment is programmed, or a whole segment is erased. A timing generator paces each operation. Its clock comes from either the system clock or an external slow strobe, chosen by a source select and slowed by a programmable predivider. Each operation lasts a fixed, parameterised number of timing-generator ticks.

Programming can only clear bits, so a programmed word becomes the old contents AND the new data. Only an erase brings bits back to one, and it does so for the whole 64-word segment. A lock input refuses all array writes. Writes that arrive while an operation runs are refused too. Every refused write raises a sticky access-violation flag. An emergency-exit input stops the timing generator at once and ends the operation without touching the cells. Array reads return cell contents when the block is idle and a fixed marker value while it is busy.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A completed program operation leaves the addressed word equal to its previous contents AND the written data. No other word changes.
- R2: A write to any address with the erase mode input set starts an erase. Once the erase completes, all 64 words of that segment (address bits [7:6]) read 16'hFFFF. Words of other segments keep their contents.
- R3: A write while the lock input is high programs nothing and leaves busy low. It sets the access-violation flag in the following cycle.
- R4: A write while busy is high and the segment-ready output is low is ignored and sets the access-violation flag.
- R5: With the system clock selected (select = 0) and predivider value d, busy stays high for exactly 35*(d+1) cycles for a single-word write and 4819*(d+1) cycles for an erase.
- R6: In segment mode (write and segment-write inputs both high), the first word takes 30 ticks and each later word takes 21 ticks. Segment-ready is high, with busy still high, whenever the next word may be written. Clearing segment-write while segment-ready is high ends the burst after 6 more ticks.
- R7: While segment-ready is high, a write to a different segment is not programmed. It sets the access-violation flag and ends the burst through the 6-tick closing phase.
- R8: Emergency exit during an operation drops busy in the next cycle. The pending word or segment is left unchanged.
- R9: While busy is high, the read data output returns 16'h3FFF regardless of address.
- R10: With the slow strobe selected (select = 1), the timing generator advances only on strobe cycles. A single-word write then needs exactly 35*(d+1) strobes.
- R11: After reset, busy, segment-ready and access-violation are low.
- R12: A violation-clear pulse with no concurrent write returns the access-violation flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lock | input | 1 | Refuse all array writes |
| cfg_wrt | input | 1 | Program mode enable |
| cfg_segwrt | input | 1 | Segment burst mode (with cfg_wrt) |
| cfg_erase | input | 1 | Segment erase mode |
| cfg_src_sel | input | 1 | Timing source: 0 system clock, 1 slow strobe |
| cfg_prediv | input | 6 | Predivider, divides by value+1 |
| emerg_exit | input | 1 | Abort the running operation |
| slow_tick | input | 1 | External slow timing strobe |
| viol_clr | input | 1 | Clear the access-violation flag |
| cpu_wr | input | 1 | Array write strobe |
| cpu_addr | input | 8 | Array word address (write and read) |
| cpu_wdata | input | 16 | Write data |
| rd_data | output | 16 | Array read data, 16'h3FFF while busy |
| busy | output | 1 | Operation in progress |
| seg_ready | output | 1 | Burst ready for the next word |
| acc_viol | output | 1 | Sticky access-violation flag |

## Verification
A miscounting tick timer shows up directly in the length of the busy pulse. The bench measures that length to the cycle for every mode and for several predivider values, so an error of even one tick appears as soon as the operation ends. A controller stuck in the wrong state shows up as busy never falling, as segment-ready missing between burst words, or as a write that was wrongly accepted or refused. Refusal is visible in the violation flag in the next cycle. A wrong program or erase datapath is hidden until the word is read back after busy falls. For that reason every operation is followed by a read compared against an AND-only model of the array.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SINGLE   = 3'd1,
    ST_SEG_PROG = 3'd2,
    ST_SEG_WAIT = 3'd3,
    ST_SEG_END  = 3'd4,
    ST_ERASE    = 3'd5
  } fstate_e;

  localparam logic [15:0] BUSY_READ_VALUE = 16'h3FFF;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen #(
  parameter int PDIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_sel,
  input  logic              slow_tick,
  input  logic [PDIV_W-1:0] prediv,
  output logic              tick
);
  logic [PDIV_W-1:0] div_q, div_d;
  logic              src_en;
  logic              div_wrap;

  assign src_en   = src_sel ? slow_tick : 1'b1;
  assign div_wrap = (div_q == prediv);
  assign tick     = run && src_en && div_wrap;

  always_comb begin
    div_d = div_q;
    if (!run)        div_d = '0;
    else if (src_en) div_d = div_wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             halt,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = tick && !load && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)                          cnt_d = load_val;
    else if (halt)                     cnt_d = '0;
    else if (tick && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int SEG_AW = 6
) (
  input  logic                     clk,
  input  logic                     prog_en,
  input  logic [ADDR_W-1:0]        prog_addr,
  input  logic [DATA_W-1:0]        prog_data,
  input  logic                     erase_en,
  input  logic [ADDR_W-SEG_AW-1:0] erase_seg,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     rd_block,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SEG_WORDS = 1 << SEG_AW;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int i = 0; i < SEG_WORDS; i++) begin
        cells[{erase_seg, SEG_AW'(i)}] <= '1;
      end
    end else if (prog_en) begin
      cells[prog_addr] <= cells[prog_addr] & prog_data;
    end
  end

  assign rd_data = rd_block ? DATA_W'(flash_ctrl_pkg::BUSY_READ_VALUE)
                            : cells[rd_addr];
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 8,
  parameter int SEG_AW        = 6,
  parameter int PDIV_W        = 6,
  parameter int SINGLE_TICKS  = 35,
  parameter int SEG_FIRST_TICKS = 30,
  parameter int SEG_NEXT_TICKS  = 21,
  parameter int SEG_END_TICKS   = 6,
  parameter int ERASE_TICKS   = 4819
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lock,
  input  logic              cfg_wrt,
  input  logic              cfg_segwrt,
  input  logic              cfg_erase,
  input  logic              cfg_src_sel,
  input  logic [PDIV_W-1:0] cfg_prediv,
  input  logic              emerg_exit,
  input  logic              slow_tick,
  input  logic              viol_clr,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              seg_ready,
  output logic              acc_viol
);
  localparam int SEG_W   = ADDR_W - SEG_AW;
  localparam int MAX_T   = max_of(max_of(SINGLE_TICKS, ERASE_TICKS),
                                  max_of(SEG_FIRST_TICKS,
                                         max_of(SEG_NEXT_TICKS, SEG_END_TICKS)));
  localparam int CNT_W   = $clog2(MAX_T + 1);

  logic              rst_ns;
  fstate_e           state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              viol_q, viol_d;
  logic              viol_set;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              run, tick, done, halt;
  logic              prog_en, erase_en;
  logic              burst_mode;
  logic              same_seg;

  flash_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  assign run = (state_q == ST_SINGLE) || (state_q == ST_SEG_PROG) ||
               (state_q == ST_SEG_END) || (state_q == ST_ERASE);

  flash_tick_gen #(.PDIV_W(PDIV_W)) u_tick (
    .clk(clk), .rst_n(rst_ns), .run(run), .src_sel(cfg_src_sel),
    .slow_tick(slow_tick), .prediv(cfg_prediv), .tick(tick)
  );

  flash_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_ns), .load(ld), .load_val(ld_val),
    .halt(halt), .tick(tick), .done(done)
  );

  flash_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_AW(SEG_AW)) u_array (
    .clk(clk), .prog_en(prog_en), .prog_addr(addr_q), .prog_data(data_q),
    .erase_en(erase_en), .erase_seg(addr_q[ADDR_W-1:SEG_AW]),
    .rd_addr(cpu_addr), .rd_block(busy), .rd_data(rd_data)
  );

  assign burst_mode = cfg_wrt && cfg_segwrt;
  assign same_seg   = (cpu_addr[ADDR_W-1:SEG_AW] == addr_q[ADDR_W-1:SEG_AW]);

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    data_d   = data_q;
    viol_set = 1'b0;
    ld       = 1'b0;
    ld_val   = '0;
    halt     = 1'b0;
    prog_en  = 1'b0;
    erase_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_wr) begin
          if (cfg_lock) begin
            viol_set = 1'b1;
          end else if (cfg_erase) begin
            state_d = ST_ERASE;
            addr_d  = cpu_addr;
            ld      = 1'b1;
            ld_val  = CNT_W'(ERASE_TICKS);
          end else if (burst_mode) begin
            state_d = ST_SEG_PROG;
            addr_d  = cpu_addr;
            data_d  = cpu_wdata;
            ld      = 1'b1;
            ld_val  = CNT_W'(SEG_FIRST_TICKS);
          end else if (cfg_wrt) begin
            state_d = ST_SINGLE;
            addr_d  = cpu_addr;
            data_d  = cpu_wdata;
            ld      = 1'b1;
            ld_val  = CNT_W'(SINGLE_TICKS);
          end
        end
      end
      ST_SEG_WAIT: begin
        if (emerg_exit) begin
          state_d = ST_IDLE;
          halt    = 1'b1;
        end else if (cpu_wr) begin
          if (cfg_lock || !same_seg) begin
            viol_set = 1'b1;
            state_d  = ST_SEG_END;
            ld       = 1'b1;
            ld_val   = CNT_W'(SEG_END_TICKS);
          end else begin
            state_d = ST_SEG_PROG;
            addr_d  = cpu_addr;
            data_d  = cpu_wdata;
            ld      = 1'b1;
            ld_val  = CNT_W'(SEG_NEXT_TICKS);
          end
        end else if (!burst_mode) begin
          state_d = ST_SEG_END;
          ld      = 1'b1;
          ld_val  = CNT_W'(SEG_END_TICKS);
        end
      end
      default: begin
        if (emerg_exit) begin
          state_d = ST_IDLE;
          halt    = 1'b1;
        end else begin
          if (cpu_wr) viol_set = 1'b1;
          if (done) begin
            unique case (state_q)
              ST_SINGLE: begin
                prog_en = 1'b1;
                state_d = ST_IDLE;
              end
              ST_SEG_PROG: begin
                prog_en = 1'b1;
                state_d = ST_SEG_WAIT;
              end
              ST_ERASE: begin
                erase_en = 1'b1;
                state_d  = ST_IDLE;
              end
              default: state_d = ST_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_comb begin
    viol_d = viol_q;
    if (viol_set)      viol_d = 1'b1;
    else if (viol_clr) viol_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      viol_q  <= viol_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign seg_ready = (state_q == ST_SEG_WAIT);
  assign acc_viol  = viol_q;
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk (
  input logic clk,
  input logic rst_ns,
  input logic cfg_lock,
  input logic emerg_exit,
  input logic viol_clr,
  input logic cpu_wr,
  input logic busy,
  input logic seg_ready,
  input logic acc_viol
);
  // R3
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cpu_wr && cfg_lock && !busy) |=> (!busy && acc_viol));

  // R4
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cpu_wr && busy && !seg_ready) |=> acc_viol);

  // R8
  emerg_stop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && emerg_exit) |=> !busy);

  // R6
  ready_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    seg_ready |-> busy);

  // R12
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (viol_clr && !cpu_wr) |=> !acc_viol);

  // R3
  idle_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!busy && !cpu_wr) |=> !busy);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .cfg_lock(cfg_lock), .emerg_exit(emerg_exit),
  .viol_clr(viol_clr), .cpu_wr(cpu_wr), .busy(busy), .seg_ready(seg_ready),
  .acc_viol(acc_viol)
);

// File: tb/flash_prog_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prog_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_lock, cfg_wrt, cfg_segwrt, cfg_erase, cfg_src_sel;
  logic [5:0]  cfg_prediv;
  logic        emerg_exit, slow_tick, viol_clr, cpu_wr;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] rd_data;
  logic        busy, seg_ready, acc_viol;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [256];

  flash_prog_ctrl u_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock), .cfg_wrt(cfg_wrt),
    .cfg_segwrt(cfg_segwrt), .cfg_erase(cfg_erase), .cfg_src_sel(cfg_src_sel),
    .cfg_prediv(cfg_prediv), .emerg_exit(emerg_exit), .slow_tick(slow_tick),
    .viol_clr(viol_clr), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .rd_data(rd_data), .busy(busy),
    .seg_ready(seg_ready), .acc_viol(acc_viol)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int busy_len(input int ticks, input int d);
    return ticks * (d + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // write pulse; returns at the negedge after the accepting edge
  task automatic pulse_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // count negedges with busy high and segment-ready low
  task automatic measure(output int n);
    n = 0;
    while (busy && !seg_ready && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a);
    cpu_addr = a;
    #0.5;
    chk(tag, rd_data, model[a]);
  endtask

  task automatic erase_seg(input logic [1:0] s, input int d, input bit timed);
    int n;
    cfg_prediv = 6'(d);
    cfg_erase = 1'b1;
    pulse_wr({s, 6'd17}, 16'h0);
    measure(n);
    cfg_erase = 1'b0;
    if (timed) chk("R5 erase length", n, busy_len(4819, d));
    for (int i = 0; i < 64; i++) model[{s, 6'(i)}] = 16'hFFFF;
  endtask

  task automatic single_wr(input logic [7:0] a, input logic [15:0] d,
                           input int dv, input bit chk_busy_read);
    int n;
    cfg_prediv = 6'(dv);
    cfg_wrt = 1'b1;
    pulse_wr(a, d);
    if (chk_busy_read) begin
      cpu_addr = a ^ 8'h5A;
      #0.5;
      chk("R9 read while busy", rd_data, 16'h3FFF);
    end
    measure(n);
    cfg_wrt = 1'b0;
    chk("R5 single length", n, busy_len(35, dv));
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n;
    int strobes;
    logic [7:0] a;
    logic [15:0] d;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cfg_lock = 0; cfg_wrt = 0; cfg_segwrt = 0; cfg_erase = 0; cfg_src_sel = 0;
    cfg_prediv = 0; emerg_exit = 0; slow_tick = 0; viol_clr = 0; cpu_wr = 0;
    cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 seg_ready", seg_ready, 0);
    chk("R11 acc_viol", acc_viol, 0);

    // R2 / R5 erase every segment, timing checked on the first
    for (int s = 0; s < 4; s++) erase_seg(2'(s), 0, s == 0);
    for (int i = 0; i < 256; i += 37) read_chk("R2 erased", 8'(i));

    // R1 R5 R9 random single writes
    for (int k = 0; k < 30; k++) begin
      a = 8'($urandom_range(0, 255));
      d = 16'($urandom);
      single_wr(a, d, $urandom_range(0, 2), k < 3);
      read_chk("R1 AND program", a);
    end
    // R1 program repeat onto same word: bits never return to 1
    single_wr(8'h10, 16'hF0F0, 0, 0);
    single_wr(8'h10, 16'h0FFF, 0, 0);
    read_chk("R1 cleared bits stay", 8'h10);
    read_chk("R1 neighbour untouched", 8'h11);

    // R3 lock refuses write
    d = model[8'h20];
    cfg_lock = 1; cfg_wrt = 1;
    pulse_wr(8'h20, 16'h0000);
    chk("R3 busy stays low", busy, 0);
    chk("R3 violation", acc_viol, 1);
    cfg_lock = 0; cfg_wrt = 0;
    read_chk("R3 word unchanged", 8'h20);

    // R12 clear
    @(negedge clk); viol_clr = 1;
    @(negedge clk); viol_clr = 0;
    chk("R12 flag cleared", acc_viol, 0);

    // R4 write during busy
    cfg_wrt = 1;
    pulse_wr(8'h30, 16'h00FF);
    repeat (4) @(negedge clk);
    cpu_addr = 8'h31; cpu_wdata = 16'h0000; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
    chk("R4 violation", acc_viol, 1);
    measure(n);
    cfg_wrt = 0;
    model[8'h30] = model[8'h30] & 16'h00FF;
    read_chk("R4 first word programmed", 8'h30);
    read_chk("R4 second word ignored", 8'h31);
    @(negedge clk); viol_clr = 1; @(negedge clk); viol_clr = 0;

    // R6 segment burst
    cfg_wrt = 1; cfg_segwrt = 1; cfg_prediv = 0;
    pulse_wr(8'h40, 16'h1234);
    measure(n);
    chk("R6 first word ticks", n, 30);
    chk("R6 ready after first", seg_ready, 1);
    chk("R6 busy in wait", busy, 1);
    pulse_wr(8'h41, 16'hABCD);
    measure(n);
    chk("R6 next word ticks", n, 21);
    @(negedge clk); cfg_segwrt = 0;
    @(negedge clk);
    measure(n);
    chk("R6 end ticks", n, 6);
    cfg_wrt = 0;
    model[8'h40] &= 16'h1234; model[8'h41] &= 16'hABCD;
    read_chk("R6 word0", 8'h40);
    read_chk("R6 word1", 8'h41);

    // R7 burst leaves its segment
    cfg_wrt = 1; cfg_segwrt = 1;
    pulse_wr(8'h50, 16'h7777);
    measure(n);
    model[8'h50] &= 16'h7777;
    pulse_wr(8'h90, 16'h0000);
    chk("R7 violation", acc_viol, 1);
    chk("R7 not ready", seg_ready, 0);
    measure(n);
    chk("R7 closing ticks", n, 6);
    cfg_wrt = 0; cfg_segwrt = 0;
    read_chk("R7 foreign word untouched", 8'h90);
    read_chk("R7 burst word kept", 8'h50);
    @(negedge clk); viol_clr = 1; @(negedge clk); viol_clr = 0;

    // R8 emergency exit of a single write
    cfg_wrt = 1;
    pulse_wr(8'h60, 16'h0000);
    repeat (10) @(negedge clk);
    emerg_exit = 1; @(negedge clk); emerg_exit = 0;
    chk("R8 busy dropped", busy, 0);
    cfg_wrt = 0;
    read_chk("R8 word unchanged", 8'h60);
    // R8 emergency exit of an erase
    cfg_erase = 1;
    pulse_wr(8'h62, 16'h0);
    cfg_erase = 0;
    repeat (100) @(negedge clk);
    emerg_exit = 1; @(negedge clk); emerg_exit = 0;
    chk("R8 erase aborted", busy, 0);
    read_chk("R8 segment unchanged", 8'h40);

    // R2 erase one segment, others kept
    erase_seg(2'd1, 1, 1);
    read_chk("R2 seg1 erased", 8'h40);
    read_chk("R2 seg1 erased hi", 8'h7F);
    read_chk("R2 seg0 kept", 8'h30);
    read_chk("R2 seg2 kept", 8'h90);

    // R10 slow strobe source
    cfg_src_sel = 1; cfg_prediv = 1; cfg_wrt = 1;
    pulse_wr(8'h05, 16'h0F0F);
    strobes = 0;
    n = 0;
    while (busy && n < 20000) begin
      slow_tick = ($urandom_range(0, 2) == 0);
      if (slow_tick) strobes++;
      n++;
      @(negedge clk);
    end
    slow_tick = 0;
    cfg_wrt = 0; cfg_src_sel = 0;
    chk("R10 strobe count", strobes, busy_len(35, 1));
    model[8'h05] &= 16'h0F0F;
    read_chk("R10 word programmed", 8'h05);

    summary();
  end
endmodule